// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block drives one NAND flash device on an 8-bit shared command/address/data bus. A scheduler hands it a single request: a page read, a page program or a block erase, with a 24-bit row address. The block stores the command and address in registers and then steps the bus through the command, address and data cycles. It waits on the device's ready line while the array operation runs. For program and erase it finishes with a status read. A top-level state machine leaves idle on an accepted request, runs the sub-sequence for the chosen operation, and returns to idle when that sub-sequence ends.

Page data passes through a local buffer. The host fills the buffer before a program and collects from it after a read. During the data cycles the block feeds every user byte to a check-code engine. On program, two code bytes are sent straight after the user data, so they land at the start of the spare area. On read, the code bytes read back are compared with a freshly computed code. A single flipped bit is repaired in the buffer before the operation completes; a double error is flagged instead.

The width of each write and read strobe comes from cycle-count parameters. The wait for the device is bounded by a timeout counter, which is sized for erase times of several milliseconds.

Top module: `nand_page_seq`

## Requirements
- R1: After reset and whenever idle, busy is low, chip enable (active low) is high, both strobes are high, and the command-latch and address-latch outputs are low.
- R2: A program (req_op 1) issues 80h, then five address bytes (two column bytes of 00h, then row bits 7:0, 15:8, 23:16), then the user bytes from the buffer starting at buffer index 0, then the two code bytes low byte first, then 10h. After the device is ready it issues 70h and reads one status byte. The command and address latch outputs are never high together.
- R3: A read (req_op 0) issues 00h, the same five address bytes, then 30h. After the device is ready it reads the user bytes into the buffer (index 0 first), followed by two stored code bytes, low byte first.
- R4: An erase (req_op 2) issues 60h, exactly three row address bytes (low byte first), then D0h. After the device is ready it issues 70h and reads one status byte.
- R5: The 16-bit check code is defined as follows. The low bits hold the XOR of the bit addresses (byte index times 8 plus bit number) of every 1 bit in the user data. Bit 15 holds the parity of the count of 1 bits. All other bits are 0.
- R6: On read, if the code read back XOR the recomputed code has bit 15 set, the buffer bit at the address given by the low bits of that difference is inverted before done, and ecc_fixed is 1 in the done cycle.
- R7: On read, if the difference is nonzero with bit 15 clear, ecc_bad is 1 in the done cycle and the buffer keeps the data exactly as read.
- R8: After the second command of an operation, no strobe falls while the ready input is low; the block waits a fixed gap, then waits for ready.
- R9: Bit 0 of the status byte read after a program or erase is reported on status_fail in the done cycle.
- R10: If ready stays low for TIMEOUT_CYC cycles, the operation ends with status_fail set and issues no further command.
- R11: busy rises the cycle after a request is accepted and stays high through a one-cycle done pulse. Requests that arrive while busy, and requests with req_op 3, are not accepted.
- R12: Every write strobe is low for exactly WE_LOW cycles and every read strobe for exactly RE_LOW cycles. The two strobes are never low together, and the data bus is not driven while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 not accepted |
| req_row | input | 24 | Row (page) address |
| busy | output | 1 | High from acceptance until return to idle |
| done | output | 1 | One-cycle completion pulse |
| status_fail | output | 1 | Device fail bit or timeout |
| ecc_fixed | output | 1 | Single-bit repair applied on read |
| ecc_bad | output | 1 | Uncorrectable mismatch on read |
| hbuf_we | input | 1 | Host buffer write (ignored while busy) |
| hbuf_addr | input | log2(PAGE_BYTES) | Host buffer write index |
| hbuf_wdata | input | 8 | Host buffer write byte |
| hbuf_raddr | input | log2(PAGE_BYTES) | Host buffer read index |
| hbuf_rdata | output | 8 | Host buffer read byte (combinational) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rdy | input | 1 | Device ready (high) / busy (low) |

## Verification
busy is due one cycle after the accepting edge. Result flags and buffer contents are due in the cycle where done is high, and the bench samples them on the falling edge of that cycle. Strobe widths and opcode order are not checked by counting cycles from the request. A behavioural device model samples the bus on rising clock edges, records each strobe's low time and each latched byte, and returns data one edge after a read strobe falls. The design captures read data on the last low cycle of the strobe, so that byte is stable when captured.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
   typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_NONE = 2'd3} op_e;
   typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_WR, BK_RD} bkind_e;
   typedef enum logic [1:0] {M_IDLE, M_RUN, M_END} main_e;
   typedef enum logic [3:0] {P_CMD1, P_ADDR, P_WDATA, P_CMD2, P_WAIT,
                             P_RDATA, P_FIX, P_SCMD, P_SRD} phase_e;
   localparam logic [7:0] OPC_RD_SETUP = 8'h00;
   localparam logic [7:0] OPC_RD_GO    = 8'h30;
   localparam logic [7:0] OPC_PG_SETUP = 8'h80;
   localparam logic [7:0] OPC_PG_GO    = 8'h10;
   localparam logic [7:0] OPC_ER_SETUP = 8'h60;
   localparam logic [7:0] OPC_ER_GO    = 8'hD0;
   localparam logic [7:0] OPC_STATUS   = 8'h70;
endpackage

// File: rtl/nseq_bus_phy.sv
module nseq_bus_phy
   import nand_seq_pkg::*;
#(
   parameter int WE_LOW  = 2,
   parameter int WE_HIGH = 2,
   parameter int RE_LOW  = 2,
   parameter int RE_HIGH = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  bkind_e     kind,
   input  logic [7:0] wbyte,
   output logic       idle,
   output logic       done,
   output logic [7:0] rbyte,
   output logic       cle,
   output logic       ale,
   output logic       we_n,
   output logic       re_n,
   output logic [7:0] dq_o,
   output logic       dq_oe,
   input  logic [7:0] dq_i
);
   localparam int MAXC = (WE_LOW > WE_HIGH ? WE_LOW : WE_HIGH) > (RE_LOW > RE_HIGH ? RE_LOW : RE_HIGH)
                       ? (WE_LOW > WE_HIGH ? WE_LOW : WE_HIGH) : (RE_LOW > RE_HIGH ? RE_LOW : RE_HIGH);
   localparam int CW = $clog2(MAXC + 1);
   localparam logic [CW-1:0] WL_END = CW'(WE_LOW - 1);
   localparam logic [CW-1:0] WH_END = CW'(WE_HIGH - 1);
   localparam logic [CW-1:0] RL_END = CW'(RE_LOW - 1);
   localparam logic [CW-1:0] RH_END = CW'(RE_HIGH - 1);

   typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_e;
   st_e           st;
   logic [CW-1:0] cnt;
   bkind_e        k_q;
   logic [7:0]    byte_q;
   logic [CW-1:0] lo_end, hi_end;

   assign lo_end = (k_q == BK_RD) ? RL_END : WL_END;
   assign hi_end = (k_q == BK_RD) ? RH_END : WH_END;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         cnt    <= '0;
         k_q    <= BK_CMD;
         byte_q <= '0;
         rbyte  <= '0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               k_q    <= kind;
               byte_q <= wbyte;
               cnt    <= '0;
               st     <= S_LOW;
            end
            S_LOW: if (cnt == lo_end) begin
               if (k_q == BK_RD) rbyte <= dq_i;
               cnt <= '0;
               st  <= S_HIGH;
            end else cnt <= cnt + 1'b1;
            default: if (cnt == hi_end) st <= S_IDLE;
                     else cnt <= cnt + 1'b1;
         endcase
      end
   end

   assign idle  = (st == S_IDLE);
   assign done  = (st == S_HIGH) && (cnt == hi_end);
   assign cle   = (st != S_IDLE) && (k_q == BK_CMD);
   assign ale   = (st != S_IDLE) && (k_q == BK_ADDR);
   assign we_n  = !((st == S_LOW) && (k_q != BK_RD));
   assign re_n  = !((st == S_LOW) && (k_q == BK_RD));
   assign dq_oe = (st != S_IDLE) && (k_q != BK_RD);
   assign dq_o  = byte_q;
endmodule

// File: rtl/nseq_ecc.sv
module nseq_ecc #(
   parameter int IDX_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       din,
   output logic [15:0]      code
);
   localparam int EA_W = IDX_W + 3;

   logic [EA_W-1:0] term [8];
   logic [EA_W-1:0] xr;

   for (genvar b = 0; b < 8; b++) begin : g_term
      assign term[b] = din[b] ? {idx, 3'(b)} : '0;
   end

   always_comb begin
      xr = '0;
      for (int b = 0; b < 8; b++) xr = xr ^ term[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code <= '0;
      else if (clr) code <= '0;
      else if (en) begin
         code[EA_W-1:0] <= code[EA_W-1:0] ^ xr;
         code[15]       <= code[15] ^ (^din);
      end
   end
endmodule

// File: rtl/nseq_pagebuf.sv
module nseq_pagebuf #(
   parameter int DEPTH = 2048,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] ra,
   output logic [7:0]    rda,
   input  logic [AW-1:0] rb,
   output logic [7:0]    rdb
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rda = mem[ra];
   assign rdb = mem[rb];
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
   import nand_seq_pkg::*;
#(
   parameter int PAGE_BYTES  = 2048,
   parameter int WE_LOW      = 2,
   parameter int WE_HIGH     = 2,
   parameter int RE_LOW      = 2,
   parameter int RE_HIGH     = 2,
   parameter int BUSY_GAP    = 8,
   parameter int TIMEOUT_CYC = 400000,
   localparam int BA_W = $clog2(PAGE_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      req_op,
   input  logic [23:0]     req_row,
   output logic            busy,
   output logic            done,
   output logic            status_fail,
   output logic            ecc_fixed,
   output logic            ecc_bad,
   input  logic            hbuf_we,
   input  logic [BA_W-1:0] hbuf_addr,
   input  logic [7:0]      hbuf_wdata,
   input  logic [BA_W-1:0] hbuf_raddr,
   output logic [7:0]      hbuf_rdata,
   output logic            nand_ce_n,
   output logic            nand_cle,
   output logic            nand_ale,
   output logic            nand_we_n,
   output logic            nand_re_n,
   output logic [7:0]      nand_dq_o,
   output logic            nand_dq_oe,
   input  logic [7:0]      nand_dq_i,
   input  logic            nand_rdy
);
   localparam int IX_W = $clog2(PAGE_BYTES + 2);
   localparam int EA_W = BA_W + 3;
   localparam int TW   = $clog2(TIMEOUT_CYC + 1);
   localparam logic [IX_W-1:0] IX_PAGE = IX_W'(PAGE_BYTES);
   localparam logic [IX_W-1:0] IX_LAST = IX_W'(PAGE_BYTES + 1);
   localparam logic [TW-1:0]   T_GAP   = TW'(BUSY_GAP);
   localparam logic [TW-1:0]   T_LIM   = TW'(TIMEOUT_CYC);

   if ((1 << BA_W) != PAGE_BYTES || PAGE_BYTES < 4) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two and at least 4");
   end
   if (EA_W > 15) begin : g_bad_code
      $error("page too large for a 16-bit check code");
   end
   if (WE_LOW < 1 || WE_HIGH < 1 || RE_LOW < 1 || RE_HIGH < 1) begin : g_bad_strobe
      $error("strobe widths must be at least one cycle");
   end
   if (BUSY_GAP >= TIMEOUT_CYC) begin : g_bad_timeout
      $error("TIMEOUT_CYC must exceed BUSY_GAP");
   end

   main_e            main_st;
   phase_e           phase;
   op_e              op_q;
   logic [23:0]      row_q;
   logic [IX_W-1:0]  idx;
   logic [TW-1:0]    wcnt;
   logic [15:0]      old_code;
   logic [15:0]      ecc_code;
   logic [15:0]      syn;

   logic             accept, busphase, b_start, b_idle, b_done;
   bkind_e           b_kind;
   logic [7:0]       b_wbyte, b_rbyte;
   logic             ecc_en;
   logic [7:0]       ecc_din;
   logic [BA_W-1:0]  c_addr;
   logic             c_we;
   logic [7:0]       c_wd, buf_rda;
   logic             user_idx;
   logic [IX_W-1:0]  idx_m2;
   logic [1:0]       rsel;
   logic [7:0]       row_byte;

   assign busy     = (main_st != M_IDLE);
   assign done     = (main_st == M_END);
   assign accept   = (main_st == M_IDLE) && req_valid && (req_op != OP_NONE);
   assign user_idx = (idx < IX_PAGE);
   assign syn      = old_code ^ ecc_code;

   assign busphase = (phase == P_CMD1) || (phase == P_ADDR) || (phase == P_WDATA) ||
                     (phase == P_CMD2) || (phase == P_RDATA) || (phase == P_SCMD) ||
                     (phase == P_SRD);
   assign b_start  = (main_st == M_RUN) && busphase && b_idle;

   assign idx_m2 = idx - IX_W'(2);
   assign rsel   = (op_q == OP_ERASE) ? idx[1:0] : idx_m2[1:0];
   always_comb begin
      case (rsel)
         2'd0:    row_byte = row_q[7:0];
         2'd1:    row_byte = row_q[15:8];
         default: row_byte = row_q[23:16];
      endcase
   end

   always_comb begin
      b_kind  = BK_CMD;
      b_wbyte = 8'h00;
      case (phase)
         P_CMD1: b_wbyte = (op_q == OP_READ) ? OPC_RD_SETUP :
                           (op_q == OP_PROG) ? OPC_PG_SETUP : OPC_ER_SETUP;
         P_CMD2: b_wbyte = (op_q == OP_READ) ? OPC_RD_GO :
                           (op_q == OP_PROG) ? OPC_PG_GO : OPC_ER_GO;
         P_SCMD: b_wbyte = OPC_STATUS;
         P_ADDR: begin
            b_kind  = BK_ADDR;
            b_wbyte = (op_q != OP_ERASE && idx < IX_W'(2)) ? 8'h00 : row_byte;
         end
         P_WDATA: begin
            b_kind  = BK_WR;
            b_wbyte = user_idx ? buf_rda : (idx == IX_PAGE) ? ecc_code[7:0] : ecc_code[15:8];
         end
         default: b_kind = BK_RD;
      endcase
   end

   assign ecc_en  = user_idx && ((b_start && phase == P_WDATA) || (b_done && phase == P_RDATA));
   assign ecc_din = (phase == P_WDATA) ? buf_rda : b_rbyte;

   assign c_addr = (phase == P_FIX) ? syn[EA_W-1:3] : idx[BA_W-1:0];
   assign c_we   = (b_done && phase == P_RDATA && user_idx) ||
                   (main_st == M_RUN && phase == P_FIX && syn[15]);
   assign c_wd   = (phase == P_FIX) ? (buf_rda ^ (8'b1 << syn[2:0])) : b_rbyte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_st     <= M_IDLE;
         phase       <= P_CMD1;
         op_q        <= OP_READ;
         row_q       <= '0;
         idx         <= '0;
         wcnt        <= '0;
         old_code    <= '0;
         status_fail <= 1'b0;
         ecc_fixed   <= 1'b0;
         ecc_bad     <= 1'b0;
      end else begin
         case (main_st)
            M_IDLE: if (accept) begin
               op_q        <= op_e'(req_op);
               row_q       <= req_row;
               phase       <= P_CMD1;
               idx         <= '0;
               wcnt        <= '0;
               status_fail <= 1'b0;
               ecc_fixed   <= 1'b0;
               ecc_bad     <= 1'b0;
               main_st     <= M_RUN;
            end
            M_RUN: case (phase)
               P_CMD1: if (b_done) begin
                  phase <= P_ADDR;
                  idx   <= '0;
               end
               P_ADDR: if (b_done) begin
                  if (idx == ((op_q == OP_ERASE) ? IX_W'(2) : IX_W'(4))) begin
                     idx   <= '0;
                     phase <= (op_q == OP_PROG) ? P_WDATA : P_CMD2;
                  end else idx <= idx + 1'b1;
               end
               P_WDATA: if (b_done) begin
                  if (idx == IX_LAST) begin
                     idx   <= '0;
                     phase <= P_CMD2;
                  end else idx <= idx + 1'b1;
               end
               P_CMD2: if (b_done) begin
                  wcnt  <= '0;
                  phase <= P_WAIT;
               end
               P_WAIT: begin
                  if (wcnt >= T_GAP && nand_rdy) begin
                     idx   <= '0;
                     phase <= (op_q == OP_READ) ? P_RDATA : P_SCMD;
                  end else if (wcnt == T_LIM) begin
                     status_fail <= 1'b1;
                     main_st     <= M_END;
                  end else wcnt <= wcnt + 1'b1;
               end
               P_RDATA: if (b_done) begin
                  if (idx == IX_PAGE) old_code[7:0] <= b_rbyte;
                  if (idx == IX_LAST) begin
                     old_code[15:8] <= b_rbyte;
                     phase          <= P_FIX;
                  end
                  idx <= idx + 1'b1;
               end
               P_FIX: begin
                  ecc_fixed <= syn[15];
                  ecc_bad   <= (syn != 16'h0) && !syn[15];
                  main_st   <= M_END;
               end
               P_SCMD: if (b_done) phase <= P_SRD;
               P_SRD: if (b_done) begin
                  status_fail <= b_rbyte[0];
                  main_st     <= M_END;
               end
               default: main_st <= M_END;
            endcase
            default: main_st <= M_IDLE;
         endcase
      end
   end

   nseq_bus_phy #(
      .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RE_LOW(RE_LOW), .RE_HIGH(RE_HIGH)
   ) u_phy (
      .clk(clk), .rst_n(rst_n), .start(b_start), .kind(b_kind), .wbyte(b_wbyte),
      .idle(b_idle), .done(b_done), .rbyte(b_rbyte),
      .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
      .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .dq_i(nand_dq_i)
   );

   nseq_ecc #(.IDX_W(BA_W)) u_ecc (
      .clk(clk), .rst_n(rst_n), .clr(accept), .en(ecc_en),
      .idx(idx[BA_W-1:0]), .din(ecc_din), .code(ecc_code)
   );

   nseq_pagebuf #(.DEPTH(PAGE_BYTES), .AW(BA_W)) u_buf (
      .clk(clk),
      .we(busy ? c_we : hbuf_we),
      .waddr(busy ? c_addr : hbuf_addr),
      .wdata(busy ? c_wd : hbuf_wdata),
      .ra(c_addr), .rda(buf_rda),
      .rb(hbuf_raddr), .rdb(hbuf_rdata)
   );

   assign nand_ce_n = !busy;
endmodule

// File: rtl/nand_page_seq_chk.sv
module nand_page_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic nand_ce_n,
   input logic nand_cle,
   input logic nand_ale,
   input logic nand_we_n,
   input logic nand_re_n,
   input logic nand_dq_oe,
   input logic nand_rdy
);
   assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale));

   assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   assert_wait_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(nand_we_n) || $fell(nand_re_n)) |-> nand_rdy);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   assert_no_drive_rd_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe);
endmodule

bind nand_page_seq nand_page_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .nand_ce_n(nand_ce_n),
   .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
   .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe), .nand_rdy(nand_rdy)
);

// File: tb/sim_nand_page_seq.sv
`timescale 1ns/1ps
module sim_nand_page_seq;
   localparam int PG = 16;
   localparam int BW = 4;
   localparam int WL = 2, WH = 1, RL = 2, RH = 1;
   localparam int TOUT = 3000;
   localparam int TR = 200, TP = 500, TE = 900;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [23:0]   req_row = '0;
   logic          busy, done, status_fail, ecc_fixed, ecc_bad;
   logic          hbuf_we = 1'b0;
   logic [BW-1:0] hbuf_addr = '0, hbuf_raddr = '0;
   logic [7:0]    hbuf_wdata = '0, hbuf_rdata;
   logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]    nand_dq_o;
   logic [7:0]    dq_in;
   logic          nand_rdy;

   nand_page_seq #(
      .PAGE_BYTES(PG), .WE_LOW(WL), .WE_HIGH(WH), .RE_LOW(RL), .RE_HIGH(RH),
      .BUSY_GAP(3), .TIMEOUT_CYC(TOUT)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_row(req_row),
      .busy(busy), .done(done), .status_fail(status_fail), .ecc_fixed(ecc_fixed), .ecc_bad(ecc_bad),
      .hbuf_we(hbuf_we), .hbuf_addr(hbuf_addr), .hbuf_wdata(hbuf_wdata),
      .hbuf_raddr(hbuf_raddr), .hbuf_rdata(hbuf_rdata),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
      .nand_dq_oe(nand_dq_oe), .nand_dq_i(dq_in), .nand_rdy(nand_rdy)
   );

   // ---------------- behavioural device model ----------------
   logic       hang = 1'b0, fail_inj = 1'b0, log_clr = 1'b0;
   int         flip_a = -1, flip_b = -1;
   logic [7:0] mem [4][PG+2];
   logic [7:0] tmp [PG+2];
   logic [7:0] addr_log [8];
   logic [7:0] cmd_log [16];
   int         cmd_n, acnt, ptr, bcnt, early;
   int         we_cnt, re_cnt, we_min, we_max, re_min, re_max;
   logic       prev_we, prev_re, smode, hang_act;
   logic [1:0] rrow;
   logic [7:0] v;

   assign nand_rdy = (bcnt == 0) && !hang_act;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 4; p++) for (int i = 0; i < PG+2; i++) mem[p][i] <= 8'hFF;
         cmd_n <= 0; acnt <= 0; ptr <= 0; bcnt <= 0; early <= 0;
         we_cnt <= 0; re_cnt <= 0; we_min <= 99; we_max <= 0; re_min <= 99; re_max <= 0;
         prev_we <= 1'b1; prev_re <= 1'b1; smode <= 1'b0; hang_act <= 1'b0;
         rrow <= '0; dq_in <= '0;
      end else begin
         prev_we <= nand_we_n;
         prev_re <= nand_re_n;
         if (bcnt != 0) bcnt <= bcnt - 1;
         if (!hang) hang_act <= 1'b0;
         if (!nand_we_n) we_cnt <= we_cnt + 1;
         else if (!prev_we) begin
            if (we_cnt < we_min) we_min <= we_cnt;
            if (we_cnt > we_max) we_max <= we_cnt;
            we_cnt <= 0;
         end
         if (!nand_re_n) re_cnt <= re_cnt + 1;
         else if (!prev_re) begin
            if (re_cnt < re_min) re_min <= re_cnt;
            if (re_cnt > re_max) re_max <= re_cnt;
            re_cnt <= 0;
         end
         if (((prev_we && !nand_we_n) || (prev_re && !nand_re_n)) && !nand_rdy) early <= early + 1;
         if (!prev_we && nand_we_n) begin
            if (nand_cle) begin
               cmd_log[cmd_n[3:0]] <= nand_dq_o;
               cmd_n <= cmd_n + 1;
               case (nand_dq_o)
                  8'h00, 8'h60: begin acnt <= 0; smode <= 1'b0; end
                  8'h80: begin
                     acnt <= 0; smode <= 1'b0; ptr <= 0;
                     for (int i = 0; i < PG+2; i++) tmp[i] <= 8'hFF;
                  end
                  8'h30: begin
                     rrow <= addr_log[2][1:0];
                     ptr  <= {addr_log[1], addr_log[0]};
                     bcnt <= TR;
                     if (hang) hang_act <= 1'b1;
                  end
                  8'h10: begin
                     for (int i = 0; i < PG+2; i++) mem[addr_log[2][1:0]][i] <= tmp[i];
                     bcnt <= TP;
                     if (hang) hang_act <= 1'b1;
                  end
                  8'hD0: begin
                     for (int i = 0; i < PG+2; i++) mem[addr_log[0][1:0]][i] <= 8'hFF;
                     bcnt <= TE;
                     if (hang) hang_act <= 1'b1;
                  end
                  8'h70: smode <= 1'b1;
                  default: ;
               endcase
            end else if (nand_ale) begin
               addr_log[acnt[2:0]] <= nand_dq_o;
               acnt <= acnt + 1;
            end else begin
               if (ptr < PG+2) tmp[ptr] <= nand_dq_o;
               ptr <= ptr + 1;
            end
         end
         if (prev_re && !nand_re_n) begin
            if (smode) dq_in <= 8'h40 | {7'd0, fail_inj};
            else begin
               v = (ptr < PG+2) ? mem[rrow][ptr] : 8'hFF;
               if (flip_a >= 0 && ptr == flip_a / 8) v = v ^ (8'd1 << (flip_a % 8));
               if (flip_b >= 0 && ptr == flip_b / 8) v = v ^ (8'd1 << (flip_b % 8));
               dq_in <= v;
               ptr <= ptr + 1;
            end
         end
      end
   end

   // ---------------- bench bookkeeping ----------------
   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [7:0] pat [PG];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] calc_code();
      logic [15:0] c = '0;
      for (int i = 0; i < PG; i++)
         for (int b = 0; b < 8; b++)
            if (pat[i][b]) begin
               c[6:0] = c[6:0] ^ 7'(i*8 + b);
               c[15]  = ~c[15];
            end
      return c;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic clear_log();
      @(negedge clk) log_clr = 1'b1;
      @(negedge clk) log_clr = 1'b0;
   endtask
   always @(posedge clk) if (log_clr) begin
      cmd_n <= 0; we_min <= 99; we_max <= 0; re_min <= 99; re_max <= 0; early <= 0;
   end

   task automatic issue(input logic [1:0] op, input logic [23:0] row);
      clear_log();
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_row = row;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R11 busy one cycle after accept", busy, 1);
   endtask

   task automatic wait_done(output int drops);
      int n = 0;
      drops = 0;
      while (done !== 1'b1 && n < 20000) begin
         @(negedge clk);
         if (!busy) drops++;
         n++;
      end
      chk(n < 20000, "R11 done reached", n, 0);
   endtask

   task automatic fill_buf();
      for (int i = 0; i < PG; i++) begin
         @(negedge clk);
         hbuf_we = 1'b1; hbuf_addr = BW'(i); hbuf_wdata = pat[i];
      end
      @(negedge clk) hbuf_we = 1'b0;
   endtask

   task automatic buf_mismatch(input int fa, input int fb, output int mism);
      logic [7:0] e;
      mism = 0;
      for (int i = 0; i < PG; i++) begin
         hbuf_raddr = BW'(i);
         #1;
         e = pat[i];
         if (fa >= 0 && i == fa / 8) e = e ^ (8'd1 << (fa % 8));
         if (fb >= 0 && i == fb / 8) e = e ^ (8'd1 << (fb % 8));
         if (hbuf_rdata !== e) mism++;
      end
   endtask

   task automatic t_reset();
      chk(busy == 0 && done == 0, "R1 idle after reset", busy, 0);
      chk(nand_ce_n == 1, "R1 ce_n high", nand_ce_n, 1);
      chk(nand_we_n == 1 && nand_re_n == 1, "R1 strobes high", {nand_we_n, nand_re_n}, 3);
      chk(nand_cle == 0 && nand_ale == 0, "R1 latches low", {nand_cle, nand_ale}, 0);
   endtask

   task automatic t_program();
      int drops, mism;
      logic [15:0] c;
      for (int i = 0; i < PG; i++) pat[i] = 8'(i * 37 + 5);
      fill_buf();
      c = calc_code();
      issue(2'd1, 24'h5A3C02);
      repeat (20) @(negedge clk);
      req_valid = 1'b1; req_op = 2'd2; req_row = 24'h000001;
      @(negedge clk) req_valid = 1'b0;
      wait_done(drops);
      chk(drops == 0, "R11 busy held during program", drops, 0);
      chk(status_fail == 0, "R9 program status pass", status_fail, 0);
      chk(cmd_n == 3 && cmd_log[0] == 8'h80 && cmd_log[1] == 8'h10 && cmd_log[2] == 8'h70,
          "R2 opcodes 80/10/70 and R11 busy request ignored", cmd_n, 3);
      chk(acnt == 5 && addr_log[0] == 8'h00 && addr_log[1] == 8'h00 && addr_log[2] == 8'h02 &&
          addr_log[3] == 8'h3C && addr_log[4] == 8'h5A, "R2 address bytes", {addr_log[2], addr_log[3], addr_log[4]}, 24'h023C5A);
      mism = 0;
      for (int i = 0; i < PG; i++) if (mem[2][i] !== pat[i]) mism++;
      chk(mism == 0, "R2 user bytes stored", mism, 0);
      chk({mem[2][PG+1], mem[2][PG]} == c, "R5 spare code", {mem[2][PG+1], mem[2][PG]}, c);
      chk(we_min == WL && we_max == WL, "R12 write strobe width", we_max, WL);
      chk(early == 0, "R8 no strobe while not ready (program)", early, 0);
   endtask

   task automatic t_read(input int fa, input int fb, input string tag);
      int drops, mism;
      for (int i = 0; i < PG; i++) begin
         @(negedge clk);
         hbuf_we = 1'b1; hbuf_addr = BW'(i); hbuf_wdata = 8'hA5;
      end
      @(negedge clk) hbuf_we = 1'b0;
      flip_a = fa; flip_b = fb;
      issue(2'd0, 24'h000002);
      wait_done(drops);
      if (fb < 0) begin
         chk(ecc_fixed == (fa >= 0), {"R6 fixed flag ", tag}, ecc_fixed, fa >= 0);
         chk(ecc_bad == 0, {"R7 no bad flag ", tag}, ecc_bad, 0);
         @(negedge clk);
         buf_mismatch(-1, -1, mism);
         chk(mism == 0, {"R3 R6 buffer data ", tag}, mism, 0);
      end else begin
         chk(ecc_bad == 1 && ecc_fixed == 0, {"R7 bad flag ", tag}, {ecc_bad, ecc_fixed}, 2);
         @(negedge clk);
         buf_mismatch(fa, fb, mism);
         chk(mism == 0, {"R7 buffer left as read ", tag}, mism, 0);
      end
      chk(cmd_n == 2 && cmd_log[0] == 8'h00 && cmd_log[1] == 8'h30, {"R3 opcodes ", tag}, cmd_n, 2);
      chk(acnt == 5, {"R3 five address bytes ", tag}, acnt, 5);
      chk(re_min == RL && re_max == RL, {"R12 read strobe width ", tag}, re_max, RL);
      chk(early == 0, {"R8 no strobe while not ready ", tag}, early, 0);
      flip_a = -1; flip_b = -1;
   endtask

   task automatic t_erase(input logic f);
      int drops, mism;
      fail_inj = f;
      issue(2'd2, 24'h000103);
      wait_done(drops);
      chk(status_fail == f, "R9 erase status bit", status_fail, f);
      chk(cmd_n == 3 && cmd_log[0] == 8'h60 && cmd_log[1] == 8'hD0 && cmd_log[2] == 8'h70,
          "R4 opcodes 60/D0/70", cmd_n, 3);
      chk(acnt == 3 && addr_log[0] == 8'h03 && addr_log[1] == 8'h01 && addr_log[2] == 8'h00,
          "R4 three row bytes", acnt, 3);
      mism = 0;
      for (int i = 0; i < PG+2; i++) if (mem[3][i] !== 8'hFF) mism++;
      chk(mism == 0, "R4 block erased", mism, 0);
      fail_inj = 1'b0;
   endtask

   task automatic t_timeout();
      int drops;
      hang = 1'b1;
      issue(2'd2, 24'h000001);
      wait_done(drops);
      chk(status_fail == 1, "R10 timeout sets fail", status_fail, 1);
      chk(cmd_n == 2, "R10 no status command after timeout", cmd_n, 2);
      @(negedge clk) hang = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reserved();
      clear_log();
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd3;
      @(negedge clk) req_valid = 1'b0;
      chk(busy == 0, "R11 op 3 not accepted", busy, 0);
      repeat (10) @(negedge clk);
      chk(cmd_n == 0 && nand_ce_n == 1, "R11 op 3 leaves bus idle", cmd_n, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_program();
      t_read(-1, -1, "clean");
      t_read(37, -1, "bit 37 flipped");
      t_read(0, -1, "bit 0 flipped");
      t_read(PG*8-1, -1, "last bit flipped");
      t_read(5, 90, "two flips");
      t_erase(1'b0);
      t_erase(1'b1);
      t_timeout();
      t_reserved();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule